// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 32-bit countdown timer for a processor's local interrupt unit. Software sets it up through three write targets on one narrow write port: a start value, a clock-divider code and a control word. The control word holds the interrupt vector, a suppress flag and a repeat flag. The counter steps down once per prescaled tick. The prescaler divides the block clock by a power of two between 1 and 128.

Writing the start value begins a new run at once, from that value. In single-run mode the count stops at zero. In repeating mode the count reloads the start value on the tick after it reaches zero, so the interval between requests is the start value plus one ticks. Each time the count steps from one to zero, the block pulses a request strobe for one cycle and presents the vector from the control word, unless the suppress flag is set. The live count is always visible on an output bus. Steering the vector into the interrupt priority logic is handled outside this block.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count reads 0, the request strobe is low and the vector output is 0. The divider starts at divide-by-2, the suppress flag is set and the repeat flag is clear.
- R2: A divider write keeps only data bits 3, 1 and 0 and ignores all other bits. The 3-bit code is {bit3, bit1, bit0}, and the tick interval is 2^((code+1) mod 8) clocks. So code 7 (data 0xB) ticks every clock, code 0 every 2 clocks and code 6 (data 0xA) every 128 clocks.
- R3: A write with wr_sel = 0 loads wr_data as both the start value and the count. The count shows that value in the cycle after the write, and the prescaler restarts from zero.
- R4: While the timer runs, the count drops by exactly one every 2^shift clocks, measured from the last start-value or divider write.
- R5: In single-run mode (control bit 17 = 0) the count stops at 0 and stays there, and one run produces exactly one request.
- R6: In repeating mode (control bit 17 = 1) the tick that finds the count at 0 reloads the start value. Requests are therefore start value + 1 ticks apart.
- R7: The request strobe is high for exactly one cycle, in the first cycle the count reads 0. At the same time irq_vector shows bits 7:0 of the control word, and it holds that value until the next request.
- R8: When control bit 16 is set, no request is raised, but counting continues unchanged and irq_vector keeps its last value.
- R9: A start value of 0 stops the timer. The count stays 0 and no request is raised.
- R10: A control-word write (wr_sel = 2) changes the mode from the next tick onward. For example, selecting repeating mode while a finished single run sits at 0 reloads the start value on the next tick.
- R11: A divider write (wr_sel = 1) restarts the prescaler and leaves the count unchanged. The next step comes one full new interval after the write.
- R12: If a register write falls in the same cycle as a tick, the start-value write wins over the decrement. A control-word write arriving in the expiry cycle does not affect that request: its suppress flag and vector are judged by the previous control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 start value, 1 divider, 2 control word, 3 none |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Live count |
| irq_req | output | 1 | One-cycle request strobe on expiry |
| irq_vector | output | 8 | Vector of the latest request |

## Verification
The risky overlap is a software write landing on the very clock edge where a prescaled tick moves the count, or where the count expires. The bench forces both cases directly. It loads a start value of 2 with divide-by-1 and writes a new start value on the next edge, when the decrement is due; the new value must appear rather than 1. It also places a control-word write on the exact expiry edge and expects the request to carry the old vector with the old suppress flag. Random phases keep colliding writes and ticks against a cycle-level reference model built from the requirements.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // write target encoding on wr_sel
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } cdt_sel_e;

  // width of the prescale shift amount
  localparam int unsigned SHIFT_W = 3;

  // three retained divider bits -> shift amount, (code + 1) mod 8
  function automatic logic [SHIFT_W-1:0] div_code_to_shift(input logic [SHIFT_W-1:0] code);
    return code + SHIFT_W'(1);
  endfunction

  // control word fields used by the counter
  typedef struct packed {
    logic       suppress;
    logic       repeat_en;
    logic [7:0] vector;
  } cdt_ctrl_t;

endpackage

// File: rtl/cdt_cfg_regs.sv
module cdt_cfg_regs
  import cdt_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_we,
  input  logic [SHIFT_W-1:0] div_code,
  input  logic               ctrl_we,
  input  logic [VEC_W-1:0]   ctrl_vec,
  input  logic               ctrl_suppress,
  input  logic               ctrl_repeat,
  output logic [SHIFT_W-1:0] shift,
  output logic [VEC_W-1:0]   vector,
  output logic               suppress,
  output logic               repeat_en
);

  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               sup_q, sup_d;
  logic               rep_q, rep_d;

  always_comb begin
    shift_d = shift_q;
    vec_d   = vec_q;
    sup_d   = sup_q;
    rep_d   = rep_q;
    if (div_we) begin
      shift_d = div_code_to_shift(div_code);
    end
    if (ctrl_we) begin
      vec_d = ctrl_vec;
      sup_d = ctrl_suppress;
      rep_d = ctrl_repeat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= div_code_to_shift('0);
      vec_q   <= '0;
      sup_q   <= 1'b1;
      rep_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      vec_q   <= vec_d;
      sup_q   <= sup_d;
      rep_q   <= rep_d;
    end
  end

  assign shift     = shift_q;
  assign vector    = vec_q;
  assign suppress  = sup_q;
  assign repeat_en = rep_q;

endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int unsigned PRE_W = (1 << SHIFT_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [PRE_W-1:0] limit;

  // last phase value before a tick, 2^shift - 1
  always_comb begin
    limit = PRE_W'((32'd1 << shift) - 32'd1);
  end

  always_comb begin
    tick   = 1'b0;
    pcnt_d = pcnt_q + PRE_W'(1);
    if (restart) begin
      pcnt_d = '0;
    end else if (pcnt_q >= limit) begin
      tick   = 1'b1;
      pcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             repeat_en,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             running;

  assign running = (start_q != '0);

  always_comb begin
    start_d = start_q;
    cnt_d   = cnt_q;
    expire  = 1'b0;
    if (load) begin
      start_d = load_val;
      cnt_d   = load_val;
    end else if (tick && running) begin
      if (cnt_q == '0) begin
        cnt_d = repeat_en ? start_q : '0;
      end else begin
        cnt_d  = cnt_q - CNT_W'(1);
        expire = (cnt_q == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned SUP_BIT  = 16,
  parameter int unsigned REP_BIT  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector
);

  localparam int unsigned PRE_W = (1 << SHIFT_W) - 1;

  logic               we_start, we_div, we_ctrl;
  logic [SHIFT_W-1:0] div_code;
  logic [SHIFT_W-1:0] shift;
  logic [VEC_W-1:0]   vector;
  logic               suppress, repeat_en;
  logic               tick, expire;

  assign we_start = wr_en && (cdt_sel_e'(wr_sel) == SEL_START);
  assign we_div   = wr_en && (cdt_sel_e'(wr_sel) == SEL_DIV);
  assign we_ctrl  = wr_en && (cdt_sel_e'(wr_sel) == SEL_CTRL);

  // divider code: bit 3 is the top bit, bits 1:0 below it
  assign div_code = {wr_data[3], wr_data[1:0]};

  cdt_cfg_regs #(
    .VEC_W(VEC_W)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .div_we        (we_div),
    .div_code      (div_code),
    .ctrl_we       (we_ctrl),
    .ctrl_vec      (wr_data[VEC_W-1:0]),
    .ctrl_suppress (wr_data[SUP_BIT]),
    .ctrl_repeat   (wr_data[REP_BIT]),
    .shift         (shift),
    .vector        (vector),
    .suppress      (suppress),
    .repeat_en     (repeat_en)
  );

  cdt_prescaler #(
    .PRE_W(PRE_W)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (we_start || we_div),
    .shift   (shift),
    .tick    (tick)
  );

  cdt_down_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (we_start),
    .load_val  (wr_data),
    .tick      (tick),
    .repeat_en (repeat_en),
    .count     (cur_count),
    .expire    (expire)
  );

  // request stage
  logic             req_q, req_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    req_d = expire && !suppress;
    vec_d = vec_q;
    if (req_d) begin
      vec_d = vector;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
    end
  end

  assign irq_req    = req_q;
  assign irq_vector = vec_q;

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned SUP_BIT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cur_count,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vector
);

  // shadow of the control word as seen through the write port
  logic             sh_sup;
  logic [VEC_W-1:0] sh_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_sup <= 1'b1;
      sh_vec <= '0;
    end else if (wr_en && wr_sel == 2'd2) begin
      sh_sup <= wr_data[SUP_BIT];
      sh_vec <= wr_data[VEC_W-1:0];
    end
  end

  // R3: a start-value write shows up in the count on the next cycle
  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (cur_count == $past(wr_data)));

  // R4: without a load, the count holds, steps down by one, or leaves zero
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd0) |=>
      (cur_count == $past(cur_count)) ||
      (cur_count == $past(cur_count) - CNT_W'(1)) ||
      ($past(cur_count) == '0));

  // R7: request only with the count at zero
  assert_req_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cur_count == '0));

  // R7: request is a single-cycle pulse
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  // R8: no request under a suppressing control word
  assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(sh_sup));

  // R12: the vector comes from the control word in force at expiry
  assert_vector_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector == $past(sh_vec)));

  // R9: a zero start value never yields a request on the next edge
  assert_zero_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data == '0) |=> !irq_req);

endmodule

bind cdt_timer cdt_timer_chk #(
  .CNT_W(CNT_W),
  .VEC_W(VEC_W),
  .SUP_BIT(SUP_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .cur_count  (cur_count),
  .irq_req    (irq_req),
  .irq_vector (irq_vector)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] cur_count;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit cmp_en = 0;
  int req_seen = 0;

  cdt_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cur_count(cur_count), .irq_req(irq_req),
    .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // tick interval exponent from a divider write, per R2
  function automatic int shift_of(input logic [31:0] d);
    int code;
    code = (d[3] ? 4 : 0) + int'(d[1:0]);
    return (code + 1) % 8;
  endfunction

  // reference model built from the requirements
  int unsigned m_el;
  int          m_shift;
  logic [31:0] m_start, m_cnt;
  logic        m_sup, m_rep, m_req;
  logic [7:0]  m_cvec, m_vec;
  logic        m_tick, m_exp, m_load;

  always_comb begin
    m_load = wr_en && wr_sel == 2'd0;
    m_tick = !(wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1)) &&
             (((m_el + 1) % (32'd1 << m_shift)) == 0);
    m_exp  = !m_load && m_tick && m_start != 0 && m_cnt == 32'd1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_el <= 0; m_shift <= 1; m_start <= 0; m_cnt <= 0;
      m_sup <= 1'b1; m_rep <= 1'b0; m_cvec <= 8'd0; m_req <= 1'b0; m_vec <= 8'd0;
    end else begin
      m_el <= (wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1)) ? 0 : m_el + 1;
      if (m_load) begin
        m_start <= wr_data; m_cnt <= wr_data;
      end else if (m_tick && m_start != 0) begin
        if (m_cnt == 0) m_cnt <= m_rep ? m_start : 32'd0;
        else            m_cnt <= m_cnt - 1;
      end
      if (wr_en && wr_sel == 2'd1) m_shift <= shift_of(wr_data);
      if (wr_en && wr_sel == 2'd2) begin
        m_cvec <= wr_data[7:0]; m_sup <= wr_data[16]; m_rep <= wr_data[17];
      end
      m_req <= m_exp && !m_sup;
      if (m_exp && !m_sup) m_vec <= m_cvec;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // continuous comparison against the model (R4 R5 R6 R10 R11)
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check("R4 R6 model count", cur_count, m_cnt);
      check("R5 R8 model request", {31'd0, irq_req}, {31'd0, m_req});
      check("R7 model vector", {24'd0, irq_vector}, {24'd0, m_vec});
    end
    if (rst_n && irq_req) req_seen++;
  end

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = $urandom;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 count", cur_count, 32'd0);
    check("R1 request", {31'd0, irq_req}, 32'd0);
    check("R1 vector", {24'd0, irq_vector}, 32'd0);
    cmp_en = 1;

    // R5 R7 single run, divide-by-1
    wr(2'd1, 32'h0000_000B);
    wr(2'd2, 32'h0000_0042);
    wr(2'd0, 32'd3);
    check("R3 loaded", cur_count, 32'd3);
    idle(1); check("R4 step", cur_count, 32'd2);
    idle(1); check("R4 step", cur_count, 32'd1);
    r0 = req_seen;
    idle(1);
    check("R7 request at zero", {31'd0, irq_req}, 32'd1);
    check("R7 vector", {24'd0, irq_vector}, 32'h42);
    idle(6);
    check("R5 stays zero", cur_count, 32'd0);
    check("R5 one request", req_seen - r0, 32'd1);

    // R10 switch to repeating while finished; R6 wrap
    wr(2'd2, 32'h0002_0055);
    check("R10 still zero", cur_count, 32'd0);
    idle(1); check("R10 reload", cur_count, 32'd3);
    idle(3);
    check("R6 request", {31'd0, irq_req}, 32'd1);
    check("R6 vector", {24'd0, irq_vector}, 32'h55);
    idle(1); check("R6 wrap", cur_count, 32'd3);

    // R8 suppressed
    wr(2'd2, 32'h0003_0066);
    r0 = req_seen;
    idle(12);
    check("R8 no request", req_seen - r0, 32'd0);
    check("R8 vector held", {24'd0, irq_vector}, 32'h55);

    // R2 R11 divider
    wr(2'd2, 32'h0000_0011);
    wr(2'd1, 32'hFFFF_FFF4);
    wr(2'd0, 32'd100);
    idle(1); check("R2 div2 hold", cur_count, 32'd100);
    idle(1); check("R2 div2 step", cur_count, 32'd99);
    idle(2); check("R2 div2 step", cur_count, 32'd98);
    wr(2'd1, 32'h0000_000A);
    check("R11 count kept", cur_count, 32'd98);
    idle(127); check("R11 div128 hold", cur_count, 32'd98);
    idle(1); check("R11 div128 step", cur_count, 32'd97);

    // R9 zero start
    wr(2'd1, 32'h0000_000B);
    wr(2'd2, 32'h0002_0023);
    wr(2'd0, 32'd0);
    r0 = req_seen;
    idle(20);
    check("R9 count", cur_count, 32'd0);
    check("R9 no request", req_seen - r0, 32'd0);

    // R12 collisions
    wr(2'd2, 32'h0000_0077);
    wr(2'd0, 32'd2);
    wr(2'd0, 32'd9);
    check("R12 start wins over tick", cur_count, 32'd9);
    idle(8);
    check("R12 before expiry", cur_count, 32'd1);
    wr(2'd2, 32'h0001_0099);
    check("R12 request from old word", {31'd0, irq_req}, 32'd1);
    check("R12 vector from old word", {24'd0, irq_vector}, 32'h77);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(7) == 0) begin
        int s;
        logic [31:0] d;
        s = $urandom_range(2);
        case (s)
          0: d = $urandom_range(24);
          1: begin
               d = $urandom & ~32'h0000_000B;
               case ($urandom_range(3))
                 0: d |= 32'h0000_000B;
                 1: d |= 32'h0000_0000;
                 2: d |= 32'h0000_0001;
                 default: d |= 32'h0000_0002;
               endcase
             end
          default: d = $urandom;
        endcase
        wr(2'(s), d);
      end else begin
        idle(1);
      end
    end
    finish_run();
  end

endmodule